// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block decides whether a two-byte conditional branch of an 8-bit processor is taken and which address runs next. The condition select names one status flag (negative, overflow, carry or zero) and the value that flag must hold. The block compares that one flag against the required value. An 8-bit signed displacement, sign-extended to the width of the program counter, is added to the address of the instruction that follows the branch.

Both results are registered and appear one clock after their inputs are presented. When the condition fails, the next address is the following instruction. When it holds, the next address is the computed target. All address arithmetic wraps modulo 2^16. The block reads the flags and never writes them.

Top module: `branch_unit`

## Requirements
- R1: While `rstN` is low, `taken` is 0 and `nextPc` is 0x0000.
- R2: `condSel[2:1]` picks the tested flag: 00 negative, 01 overflow, 10 carry, 11 zero. `condSel[0]` is the value that flag must have for `taken` to be 1.
- R3: The three flags that `condSel` does not pick have no effect on `taken` or `nextPc`.
- R4: When the condition fails, `nextPc` equals `pc + 2`.
- R5: When the condition holds, `nextPc` equals `pc + 2` plus `offset` read as a two's-complement byte, where 0x80 is -128 and 0x7F is +127.
- R6: A taken target always lies between `pc - 126` and `pc + 129`, both ends included.
- R7: All address sums are taken modulo 65536, so targets wrap across 0xFFFF and 0x0000.
- R8: `taken` and `nextPc` reflect the inputs sampled at the previous rising clock edge, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| condSel | input | 3 | Flag select (bits 2:1) and required flag value (bit 0) |
| flagN | input | 1 | Negative flag |
| flagV | input | 1 | Overflow flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| pc | input | 16 | Address of the branch instruction |
| offset | input | 8 | Signed branch displacement |
| taken | output | 1 | Condition held on the sampled inputs |
| nextPc | output | 16 | Address to execute next |

## Verification
The assertions assume that every input is a known value at each rising edge once reset has been released. They compare outputs against inputs captured one edge earlier, so their checks begin only after the first edge out of reset. The stimulus drives all inputs on falling edges, so inputs never change near the sampling edge. Random patterns cover every select code and every flag combination. Directed patterns place `pc` near both ends of the address space and use the two extreme displacements, which exercises wrap-around and the range bound.

// File: rtl/branch_unit_pkg.sv
package branch_unit_pkg;
  // Number of bytes a conditional branch occupies.
  localparam int unsigned BranchLen = 2;

  // Strobes passed from the condition logic to the address datapath.
  typedef struct packed {
    logic takeBranch;  // condition met: select the relative target
    logic capture;     // register a new next-address value
  } brStrobe_t;
endpackage

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import branch_unit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] condSel,
  input  logic [3:0] flagVec,   // index 0 N, 1 V, 2 C, 3 Z
  output brStrobe_t  strobe,
  output logic       takenQ
);
  logic chosenFlag;
  logic condMet;

  // The upper select bits index the flag vector. The low bit gives the required value.
  assign chosenFlag = flagVec[condSel[2:1]];
  assign condMet    = (chosenFlag == condSel[0]);

  always_comb begin
    strobe            = '0;
    strobe.takeBranch = condMet;
    strobe.capture    = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) takenQ <= 1'b0;
    else       takenQ <= condMet;
  end
endmodule

// File: rtl/branch_dpath.sv
module branch_dpath
  import branch_unit_pkg::*;
#(
  parameter int unsigned PcW   = 16,
  parameter int unsigned OffW  = 8,
  parameter int unsigned InstrLen = BranchLen
) (
  input  logic            clk,
  input  logic            rstN,
  input  brStrobe_t       strobe,
  input  logic [PcW-1:0]  pc,
  input  logic [OffW-1:0] offset,
  output logic [PcW-1:0]  nextPcQ
);
  localparam int unsigned ExtW = PcW - OffW;

  logic [PcW-1:0] fallThru;
  logic [PcW-1:0] offExt;
  logic [PcW-1:0] target;

  // Sums wrap naturally at PcW bits.
  assign fallThru = pc + PcW'(InstrLen);
  assign offExt   = {{ExtW{offset[OffW-1]}}, offset};
  assign target   = fallThru + offExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                nextPcQ <= '0;
    else if (strobe.capture)  nextPcQ <= strobe.takeBranch ? target : fallThru;
  end
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_unit_pkg::*;
#(
  parameter int unsigned PcW  = 16,
  parameter int unsigned OffW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      condSel,
  input  logic            flagN,
  input  logic            flagV,
  input  logic            flagZ,
  input  logic            flagC,
  input  logic [PcW-1:0]  pc,
  input  logic [OffW-1:0] offset,
  output logic            taken,
  output logic [PcW-1:0]  nextPc
);
  brStrobe_t strobe;

  branch_ctrl ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .condSel (condSel),
    .flagVec ({flagZ, flagC, flagV, flagN}),
    .strobe  (strobe),
    .takenQ  (taken)
  );

  branch_dpath #(.PcW(PcW), .OffW(OffW)) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pc      (pc),
    .offset  (offset),
    .nextPcQ (nextPc)
  );
endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk #(
  parameter int unsigned PcW  = 16,
  parameter int unsigned OffW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [2:0]      condSel,
  input logic            flagN,
  input logic            flagV,
  input logic            flagZ,
  input logic            flagC,
  input logic [PcW-1:0]  pc,
  input logic [OffW-1:0] offset,
  input logic            taken,
  input logic [PcW-1:0]  nextPc
);
  logic            primed;
  logic [2:0]      selQ;
  logic            nQ, vQ, zQ, cQ;
  logic [PcW-1:0]  pcQ;
  logic [OffW-1:0] offQ;
  logic            wantFlag;
  logic [PcW-1:0]  delta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed <= 1'b0;
      selQ <= '0; nQ <= 1'b0; vQ <= 1'b0; zQ <= 1'b0; cQ <= 1'b0;
      pcQ <= '0; offQ <= '0;
    end else begin
      primed <= 1'b1;
      selQ <= condSel; nQ <= flagN; vQ <= flagV; zQ <= flagZ; cQ <= flagC;
      pcQ <= pc; offQ <= offset;
    end
  end

  always_comb begin
    case (selQ[2:1])
      2'b00:   wantFlag = nQ;
      2'b01:   wantFlag = vQ;
      2'b10:   wantFlag = cQ;
      default: wantFlag = zQ;
    endcase
  end

  assign delta = nextPc - pcQ;

  // R2, R8: taken follows the selected flag of the previous edge
  assert_cond_select_R2: assert property (@(posedge clk) disable iff (!rstN || !primed)
    taken == (wantFlag == selQ[0]));

  // R4: not taken goes to the following instruction
  assert_fall_through_R4: assert property (@(posedge clk) disable iff (!rstN || !primed)
    !taken |-> nextPc == PcW'(pcQ + PcW'(2)));

  // R5: taken goes to the sign-extended relative target
  assert_rel_target_R5: assert property (@(posedge clk) disable iff (!rstN || !primed)
    taken |-> nextPc == PcW'(pcQ + PcW'(2) + PcW'($signed(offQ))));

  // R6: taken target lies within the reachable window
  assert_reach_window_R6: assert property (@(posedge clk) disable iff (!rstN || !primed)
    taken |-> ($signed(delta) >= -126 && $signed(delta) <= 129));
endmodule

bind branch_unit branch_unit_chk #(.PcW(PcW), .OffW(OffW)) chk (.*);

// File: tb/branch_unit_test.sv
`timescale 1ns/1ps
module branch_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  condSel = '0;
  logic        flagN = 0, flagV = 0, flagZ = 0, flagC = 0;
  logic [15:0] pc = '0;
  logic [7:0]  offset = '0;
  logic        taken;
  logic [15:0] nextPc;

  int checks = 0;
  int fails  = 0;
  int expTaken = 0;
  int expNext  = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  branch_unit uut (.*);

  function automatic int refTaken(int sel, int n, int v, int z, int c);
    int f;
    case (sel / 2)
      0: f = n;
      1: f = v;
      2: f = c;
      default: f = z;
    endcase
    return (f == sel % 2) ? 1 : 0;
  endfunction

  function automatic int refNext(int tk, int p, int off);
    int d;
    d = (off >= 128) ? off - 256 : off;
    if (tk == 0) d = 0;
    return (p + 2 + d + 65536) % 65536;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: capture each edge's inputs (R8 latency)
  always @(posedge clk) begin
    if (!rstN) begin
      expTaken = 0; expNext = 0;
    end else begin
      expTaken = refTaken(int'(condSel), int'(flagN), int'(flagV), int'(flagZ), int'(flagC));
      expNext  = refNext(expTaken, int'(pc), int'(offset));
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2/R8 taken", int'(taken), expTaken);
      check(expTaken != 0 ? "R5/R7 target" : "R4/R7 fall-through", int'(nextPc), expNext);
    end
  end

  task automatic apply(int sel, int n, int v, int z, int c, int p, int off);
    @(negedge clk);
    condSel = 3'(sel); flagN = 1'(n); flagV = 1'(v); flagZ = 1'(z); flagC = 1'(c);
    pc = 16'(p); offset = 8'(off);
    @(negedge clk);  // one edge has captured the inputs
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    condSel = 3'd7; flagZ = 1; pc = 16'h1234; offset = 8'h10;
    repeat (3) @(negedge clk);
    check("R1 taken in reset", int'(taken), 0);
    check("R1 nextPc in reset", int'(nextPc), 0);
    rstN = 1'b1;

    // R2: every select code with its flag matching and mismatching
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 2; f++) begin
        int n, v, z, c;
        n = 0; v = 0; z = 0; c = 0;
        case (s / 2) 0: n = f; 1: v = f; 2: c = f; default: z = f; endcase
        apply(s, n, v, z, c, 16'h4000, 8'h04);
        check("R2 select code", int'(taken), (f == s % 2) ? 1 : 0);
      end
    end

    // R3: unselected flags toggled, result unchanged
    for (int s = 0; s < 8; s++) begin
      for (int o = 0; o < 16; o++) begin
        int n, v, z, c;
        n = o & 1; v = (o >> 1) & 1; z = (o >> 2) & 1; c = (o >> 3) & 1;
        case (s / 2) 0: n = s % 2; 1: v = s % 2; 2: c = s % 2; default: z = s % 2; endcase
        apply(s, n, v, z, c, 16'h2000, 8'hF0);
        check("R3 other flags ignored taken", int'(taken), 1);
        check("R3 other flags ignored nextPc", int'(nextPc), 16'h1FF2);
      end
    end

    // R4: not taken, including wrap (R7)
    apply(7, 0, 0, 0, 0, 16'h1000, 8'h55);
    check("R4 fall-through", int'(nextPc), 16'h1002);
    apply(7, 0, 0, 0, 0, 16'hFFFF, 8'h55);
    check("R4/R7 fall-through wrap", int'(nextPc), 16'h0001);

    // R5/R6: extreme displacements
    apply(5, 0, 0, 0, 1, 16'h1000, 8'h80);
    check("R5/R6 offset -128 reach", int'(nextPc), 16'h0F82);
    apply(5, 0, 0, 0, 1, 16'h1000, 8'h7F);
    check("R5/R6 offset +127 reach", int'(nextPc), 16'h1081);
    apply(5, 0, 0, 0, 1, 16'h1000, 8'hFE);
    check("R5 offset -2 self loop", int'(nextPc), 16'h1000);

    // R7: wrap across both ends
    apply(1, 1, 0, 0, 0, 16'hFFFE, 8'h05);
    check("R7 forward wrap", int'(nextPc), 16'h0005);
    apply(1, 1, 0, 0, 0, 16'h0010, 8'hE0);
    check("R7 backward wrap", int'(nextPc), 16'hFFF2);

    // Random patterns checked by the per-cycle model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      condSel = 3'($urandom); {flagN, flagV, flagZ, flagC} = 4'($urandom);
      pc = 16'($urandom); offset = 8'($urandom);
    end
    @(negedge clk);

    // R1: asynchronous reset mid-run
    done = 1;
    rstN = 1'b0;
    #1;
    check("R1 taken after reset", int'(taken), 0);
    check("R1 nextPc after reset", int'(nextPc), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule